// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit

This is a combinational shifter for a microcoded integer datapath. It handles three shifts: logical left, logical right and arithmetic right. It handles four rotates: left, right, left through carry and right through carry. The operation works on an 8-, 16-, 32- or 64-bit slice of the operand. The unit returns a zero-extended result together with the carry flag, an extended copy of the carry flag and the overflow flag. Each operation has its own rule for how those flags are formed.

The microcode sequencer supplies the operand, a count, the current carry flag, an opcode, a size code and a flag-write request. The count may come from a register or from an immediate field. The unit cuts it down to five bits for the three narrow sizes and to six bits for the 64-bit size. A count that is zero after this cut leaves the flags alone, and a valid strobe tells the flag register whether to take the new values.

Top module: `shrot_unit`

## Requirements
- R1: The count is `amt_i[4:0]` when `size_i` is 0 (8-bit), 1 (16-bit) or 2 (32-bit), and `amt_i[5:0]` when `size_i` is 3 (64-bit). The higher count bits have no effect.
- R2: When the cut count is zero, the result equals the sized operand, `flag_vld_o` is 0, `cf_o` equals `cf_i` and `of_o` is 0.
- R3: Opcode 0 (left shift) fills with zeros. CF is the last bit shifted out, which is 0 once the count exceeds the width. OF is CF XOR the result MSB.
- R4: Opcode 1 (logical right shift) fills with zeros. CF is the last bit shifted out. OF is the MSB of the original operand.
- R5: Opcode 2 (arithmetic right shift) fills with copies of the sign bit. CF is the last bit shifted out, which is the sign bit once the count reaches the width. OF is 0.
- R6: Opcode 3 (rotate left) rotates by the count modulo the width. CF is the result LSB. OF is the result MSB XOR the result LSB.
- R7: Opcode 4 (rotate right) rotates by the count modulo the width. CF is the result MSB. OF is the XOR of the two highest bits of the original operand.
- R8: Opcode 5 (rotate left through carry) rotates the width+1 bit value {CF, operand} by the count modulo width+1. CF becomes the bit that lands above the result. OF is the old CF XOR the result MSB.
- R9: Opcode 6 (rotate right through carry) works the same way as R8 in the right direction. OF is the old CF XOR the original operand MSB.
- R10: `ecf_o` always equals `cf_o`.
- R11: Result bits above the operand size are 0, and operand bits above the size have no effect.
- R12: `flag_vld_o` is 1 exactly when `flag_wr_i` is 1 and the cut count is non-zero. When it is 0, `cf_o` repeats `cf_i` and `of_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code, values 0 to 6 as in R3 to R9 |
| size_i | input | 2 | Operand size code: 0=8, 1=16, 2=32, 3=64 bits |
| opnd_i | input | 64 | Operand value |
| amt_i | input | 8 | Shift or rotate count, from register or immediate |
| cf_i | input | 1 | Current carry flag |
| flag_wr_i | input | 1 | Flag update requested |
| res_o | output | 64 | Zero-extended result |
| cf_o | output | 1 | New carry flag |
| ecf_o | output | 1 | New extended carry flag |
| of_o | output | 1 | New overflow flag |
| flag_vld_o | output | 1 | Flag outputs are to be written |

## Verification
The bench aims at counts that equal or exceed the operand width. A shifter that takes its carry from the wrong end of the shifted vector, or that wraps a shift like a rotate, returns a stale or non-zero CF at those counts. Counts whose upper bits are cut away are applied to find a unit that truncates by the wrong width, and so shifts a byte by 32 or skips a 64-bit shift by 32. Rotates through carry with counts of width and width+1 find a modulo taken over the width instead of width+1, since that error puts the carry bit back in the wrong place. Each overflow rule is exercised with operands whose two top bits differ, so that an OF formula copied from another opcode produces the wrong value.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6
    } shrot_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } shrot_size_e;

    typedef struct packed {
        logic cf;
        logic of;
    } shrot_flags_t;

    // Count register width: wide enough to hold the largest lane width plus one.
    localparam int CNT_W = 7;

    function automatic logic is_plain_rot(shrot_op_e op);
        return (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic is_carry_rot(shrot_op_e op);
        return (op == OP_RCL) || (op == OP_RCR);
    endfunction

endpackage

// File: rtl/shrot_amount.sv
module shrot_amount
    import shrot_pkg::*;
#(
    parameter int AMT_W = 8,
    parameter int XLEN  = 64,
    parameter int NLANE = 4
) (
    input  logic [AMT_W-1:0] amt_i,
    input  logic [1:0]       size_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int LONG_W  = $clog2(XLEN);
    localparam int SHORT_W = LONG_W - 1;

    logic unused_amt;
    assign unused_amt = ^amt_i[AMT_W-1:LONG_W];

    always_comb begin
        if (size_i == 2'(NLANE - 1))
            cnt_o = CNT_W'(amt_i[LONG_W-1:0]);
        else
            cnt_o = CNT_W'(amt_i[SHORT_W-1:0]);
    end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  shrot_op_e        op_i,
    input  logic [W-1:0]     a_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cf_i,
    output logic [W-1:0]     res_o,
    output shrot_flags_t     fl_o
);
    localparam logic [CNT_W-1:0] W_C   = CNT_W'(W);
    localparam logic [CNT_W-1:0] WP1_C = CNT_W'(W + 1);

    logic [CNT_W-1:0] rot_n, rc_n;
    logic [2*W-1:0]   shl_x, shr_x, sar_x, rol_x, ror_x;
    logic [2*W+1:0]   rcl_x, rcr_x;

    assign rot_n = cnt_i % W_C;
    assign rc_n  = cnt_i % WP1_C;

    assign shl_x = {{W{1'b0}}, a_i} << cnt_i;
    assign shr_x = {a_i, {W{1'b0}}} >> cnt_i;
    assign sar_x = $signed({a_i, {W{1'b0}}}) >>> cnt_i;
    assign rol_x = {a_i, a_i} << rot_n;
    assign ror_x = {a_i, a_i} >> rot_n;
    assign rcl_x = {cf_i, a_i, cf_i, a_i} << rc_n;
    assign rcr_x = {cf_i, a_i, cf_i, a_i} >> rc_n;

    logic unused_bits;
    assign unused_bits = ^{shl_x[2*W-1:W+1], shr_x[W-2:0], sar_x[W-2:0],
                           rol_x[W-1:0], ror_x[2*W-1:W], rcl_x[W:0],
                           rcr_x[2*W+1:W+1]};

    always_comb begin
        res_o = a_i;
        fl_o  = '{cf: cf_i, of: 1'b0};
        unique case (op_i)
            OP_SHL: begin
                res_o = shl_x[W-1:0];
                fl_o.cf = shl_x[W];
                fl_o.of = shl_x[W] ^ shl_x[W-1];
            end
            OP_SHR: begin
                res_o = shr_x[2*W-1:W];
                fl_o.cf = shr_x[W-1];
                fl_o.of = a_i[W-1];
            end
            OP_SAR: begin
                res_o = sar_x[2*W-1:W];
                fl_o.cf = sar_x[W-1];
                fl_o.of = 1'b0;
            end
            OP_ROL: begin
                res_o = rol_x[2*W-1:W];
                fl_o.cf = rol_x[W];
                fl_o.of = rol_x[2*W-1] ^ rol_x[W];
            end
            OP_ROR: begin
                res_o = ror_x[W-1:0];
                fl_o.cf = ror_x[W-1];
                fl_o.of = a_i[W-1] ^ a_i[W-2];
            end
            OP_RCL: begin
                res_o = rcl_x[2*W:W+1];
                fl_o.cf = rcl_x[2*W+1];
                fl_o.of = cf_i ^ rcl_x[2*W];
            end
            OP_RCR: begin
                res_o = rcr_x[W-1:0];
                fl_o.cf = rcr_x[W];
                fl_o.of = cf_i ^ a_i[W-1];
            end
            default: ;
        endcase
    end

    always_comb begin
        if (is_plain_rot(op_i)) begin
            // R6 R7
            rotate_pop_chk: assert ($countones(res_o) == $countones(a_i));
        end
        if (is_carry_rot(op_i)) begin
            // R8 R9
            carry_pop_chk: assert ($countones({fl_o.cf, res_o}) == $countones({cf_i, a_i}));
        end
        if (op_i == OP_SAR) begin
            // R5
            sar_sign_chk: assert (res_o[W-1] == a_i[W-1]);
        end
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int AMT_W = 8
) (
    input  logic [2:0]       op_i,
    input  logic [1:0]       size_i,
    input  logic [XLEN-1:0]  opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             cf_i,
    input  logic             flag_wr_i,
    output logic [XLEN-1:0]  res_o,
    output logic             cf_o,
    output logic             ecf_o,
    output logic             of_o,
    output logic             flag_vld_o
);
    localparam int NLANE = $clog2(XLEN / 8) + 1;

    shrot_op_e        op;
    logic [CNT_W-1:0] cnt;
    logic [XLEN-1:0]  lane_res [NLANE];
    shrot_flags_t     lane_fl  [NLANE];
    shrot_flags_t     sel_fl;

    assign op = shrot_op_e'(op_i);

    shrot_amount #(.AMT_W(AMT_W), .XLEN(XLEN), .NLANE(NLANE)) u_amount (
        .amt_i  (amt_i),
        .size_i (size_i),
        .cnt_o  (cnt)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] r_w;
        shrot_lane #(.W(LW)) u_lane (
            .op_i  (op),
            .a_i   (opnd_i[LW-1:0]),
            .cnt_i (cnt),
            .cf_i  (cf_i),
            .res_o (r_w),
            .fl_o  (lane_fl[g])
        );
        assign lane_res[g] = XLEN'(r_w);
    end

    assign sel_fl     = lane_fl[size_i];
    assign res_o      = lane_res[size_i];
    assign flag_vld_o = flag_wr_i && (cnt != '0);
    assign cf_o       = flag_vld_o ? sel_fl.cf : cf_i;
    assign ecf_o      = cf_o;
    assign of_o       = flag_vld_o ? sel_fl.of : 1'b0;

    logic [XLEN-1:0] sz_mask;
    assign sz_mask = (XLEN'(1) << (8 << size_i)) - XLEN'(1);

    always_comb begin
        if (cnt == '0) begin
            // R2
            zero_count_chk: assert (res_o == (opnd_i & sz_mask) && !flag_vld_o && cf_o == cf_i);
        end
        // R11
        upper_zero_chk: assert ((res_o & ~sz_mask) == '0);
    end
endmodule

// File: tb/shrot_unit_bench.sv
`timescale 1ns/1ps
module shrot_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op;
    logic [1:0]  size;
    logic [63:0] opnd;
    logic [7:0]  amt;
    logic        cf_in, fwr;
    logic [63:0] res;
    logic        cf_out, ecf_out, of_out, vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    shrot_unit u_shrot_unit (
        .op_i(op), .size_i(size), .opnd_i(opnd), .amt_i(amt),
        .cf_i(cf_in), .flag_wr_i(fwr), .res_o(res), .cf_o(cf_out),
        .ecf_o(ecf_out), .of_o(of_out), .flag_vld_o(vld)
    );

    // Bit-serial reference built from the requirement text.
    task automatic model(input logic [2:0] o, input logic [1:0] s, input logic [63:0] a,
                         input logic [7:0] n, input logic c0, input logic we,
                         output logic [63:0] r, output logic c, output logic ov,
                         output logic v);
        int w = 8 << s;
        logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        int k = (s == 2'd3) ? int'(n[5:0]) : int'(n[4:0]);
        logic [63:0] x = a & m;
        logic cc = c0;
        logic b;
        for (int i = 0; i < k; i++) begin
            case (o)
                3'd0: begin cc = x[w-1]; x = (x << 1) & m; end
                3'd1: begin cc = x[0]; x = x >> 1; end
                3'd2: begin cc = x[0]; b = x[w-1]; x = (x >> 1) | (64'(b) << (w-1)); end
                3'd3: begin b = x[w-1]; x = ((x << 1) | 64'(b)) & m; cc = x[0]; end
                3'd4: begin b = x[0]; x = (x >> 1) | (64'(b) << (w-1)); cc = x[w-1]; end
                3'd5: begin b = x[w-1]; x = ((x << 1) | 64'(cc)) & m; cc = b; end
                3'd6: begin b = x[0]; x = (x >> 1) | (64'(cc) << (w-1)); cc = b; end
                default: ;
            endcase
        end
        r = x;
        v = we && (k != 0);
        if (!v) begin
            c = c0; ov = 1'b0;
        end else begin
            c = cc;
            case (o)
                3'd0: ov = cc ^ x[w-1];
                3'd1: ov = a[w-1];
                3'd2: ov = 1'b0;
                3'd3: ov = x[w-1] ^ x[0];
                3'd4: ov = a[w-1] ^ a[w-2];
                3'd5: ov = c0 ^ x[w-1];
                3'd6: ov = c0 ^ a[w-1];
                default: ov = 1'b0;
            endcase
        end
    endtask

    task automatic vec(input string req, input logic [2:0] o, input logic [1:0] s,
                       input logic [63:0] a, input logic [7:0] n, input logic c0,
                       input logic we);
        logic [63:0] er;
        logic ec, eo, ev;
        @(posedge clk);
        op = o; size = s; opnd = a; amt = n; cf_in = c0; fwr = we;
        model(o, s, a, n, c0, we, er, ec, eo, ev);
        @(negedge clk);
        n_chk++;
        if (res !== er || cf_out !== ec || ecf_out !== ec || of_out !== eo || vld !== ev) begin
            n_bad++;
            $display("FAIL %s op=%0d sz=%0d a=%h n=%0d: got res=%h cf=%b ecf=%b of=%b vld=%b exp res=%h cf=%b ecf=%b of=%b vld=%b",
                     req, o, s, a, n, res, cf_out, ecf_out, of_out, vld, er, ec, ec, eo, ev);
        end
    endtask

    task automatic t_reset;   // R2: idle inputs after reset
        vec("R2", 3'd0, 2'd0, 64'h0, 8'h0, 1'b0, 1'b0);
    endtask

    task automatic t_trunc;   // R1
        vec("R1", 3'd0, 2'd0, 64'h81, 8'hE1, 1'b0, 1'b1);
        vec("R1", 3'd1, 2'd2, 64'h8000_0001, 8'h20, 1'b1, 1'b1);
        vec("R1", 3'd1, 2'd3, 64'h8000_0001_0000_0000, 8'h20, 1'b0, 1'b1);
        vec("R1", 3'd0, 2'd3, 64'h1, 8'hC1, 1'b0, 1'b1);
        vec("R1", 3'd3, 2'd1, 64'h8001, 8'h31, 1'b0, 1'b1);
    endtask

    task automatic t_zero;    // R2
        vec("R2", 3'd0, 2'd1, 64'hFFFF_8001, 8'h00, 1'b1, 1'b1);
        vec("R2", 3'd5, 2'd0, 64'h5A, 8'h40, 1'b1, 1'b1);
        vec("R2", 3'd2, 2'd3, 64'hF000_0000_0000_0000, 8'hC0, 1'b0, 1'b1);
    endtask

    task automatic t_shl;     // R3
        vec("R3", 3'd0, 2'd0, 64'h40, 8'd1, 1'b0, 1'b1);
        vec("R3", 3'd0, 2'd0, 64'hC0, 8'd1, 1'b0, 1'b1);
        vec("R3", 3'd0, 2'd0, 64'h01, 8'd8, 1'b0, 1'b1);
        vec("R3", 3'd0, 2'd0, 64'hFF, 8'd20, 1'b1, 1'b1);
        vec("R3", 3'd0, 2'd3, 64'h3, 8'd63, 1'b0, 1'b1);
    endtask

    task automatic t_shr;     // R4
        vec("R4", 3'd1, 2'd0, 64'h81, 8'd1, 1'b0, 1'b1);
        vec("R4", 3'd1, 2'd1, 64'h8000, 8'd16, 1'b0, 1'b1);
        vec("R4", 3'd1, 2'd2, 64'hF000_0000, 8'd31, 1'b0, 1'b1);
    endtask

    task automatic t_sar;     // R5
        vec("R5", 3'd2, 2'd0, 64'h85, 8'd2, 1'b0, 1'b1);
        vec("R5", 3'd2, 2'd0, 64'h80, 8'd12, 1'b0, 1'b1);
        vec("R5", 3'd2, 2'd2, 64'h7000_0001, 8'd4, 1'b0, 1'b1);
    endtask

    task automatic t_rol;     // R6
        vec("R6", 3'd3, 2'd0, 64'h81, 8'd1, 1'b0, 1'b1);
        vec("R6", 3'd3, 2'd0, 64'h96, 8'd8, 1'b0, 1'b1);
        vec("R6", 3'd3, 2'd3, 64'h8000_0000_0000_0002, 8'd33, 1'b0, 1'b1);
    endtask

    task automatic t_ror;     // R7
        vec("R7", 3'd4, 2'd0, 64'h01, 8'd1, 1'b0, 1'b1);
        vec("R7", 3'd4, 2'd1, 64'h4001, 8'd5, 1'b0, 1'b1);
        vec("R7", 3'd4, 2'd2, 64'hA000_0000, 8'd32 + 8'd64, 1'b0, 1'b1);
    endtask

    task automatic t_rcl;     // R8
        vec("R8", 3'd5, 2'd0, 64'h80, 8'd1, 1'b0, 1'b1);
        vec("R8", 3'd5, 2'd0, 64'h55, 8'd9, 1'b1, 1'b1);
        vec("R8", 3'd5, 2'd0, 64'hC3, 8'd8, 1'b1, 1'b1);
        vec("R8", 3'd5, 2'd1, 64'h8001, 8'd17, 1'b0, 1'b1);
    endtask

    task automatic t_rcr;     // R9
        vec("R9", 3'd6, 2'd0, 64'h01, 8'd1, 1'b1, 1'b1);
        vec("R9", 3'd6, 2'd0, 64'h81, 8'd9, 1'b0, 1'b1);
        vec("R9", 3'd6, 2'd2, 64'h8000_0001, 8'd31, 1'b1, 1'b1);
    endtask

    task automatic t_ecf;     // R10
        vec("R10", 3'd0, 2'd1, 64'h8000, 8'd1, 1'b0, 1'b1);
        vec("R10", 3'd6, 2'd3, 64'h1, 8'd1, 1'b0, 1'b1);
    endtask

    task automatic t_upper;   // R11
        vec("R11", 3'd4, 2'd0, 64'hFFFF_FFFF_FFFF_FF01, 8'd1, 1'b0, 1'b1);
        vec("R11", 3'd2, 2'd1, 64'hABCD_0000_0000_8000, 8'd3, 1'b0, 1'b1);
    endtask

    task automatic t_flagwr;  // R12
        vec("R12", 3'd0, 2'd0, 64'h80, 8'd1, 1'b1, 1'b0);
        vec("R12", 3'd1, 2'd2, 64'h1, 8'd1, 1'b0, 1'b0);
    endtask

    initial begin
        op = '0; size = '0; opnd = '0; amt = '0; cf_in = 1'b0; fwr = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        wait (!rst);
        t_reset(); t_trunc(); t_zero(); t_shl(); t_shr(); t_sar();
        t_rol(); t_ror(); t_rcl(); t_rcr(); t_ecf(); t_upper(); t_flagwr();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no completion, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule